// File: doc/BRIEF.md
# Shared-Bus Event Counter Monitor

This block sits beside a shared parallel bus and only listens. On every bus clock it sorts the clock into one of three kinds. A clock is idle when no transaction is in progress. It is a data clock when a word actually moves. It is an overhead clock when a transaction is open but the initiator or the target is holding off. The block counts idle clocks and data clocks. For each of five external masters it also counts transactions begun and the clocks spent waiting for the bus. The waiting count includes clocks where the master asks for the bus while someone else holds it. Dividing a master's wait count by its transaction count gives its average acquisition latency.

Software reaches the block through a small synchronous register port. A control word selects the monitoring mode and can zero every counter in one write. Counting happens only while the mode field holds the bus-monitor code. Each counter stops at its maximum value instead of wrapping, and then raises a sticky overflow flag.

Top module: `pci_evmon`

## Requirements
- R1: After reset all counters, all overflow flags, the mode field and `rdata` are zero.
- R2: A clock is a data clock when `irdy_n` and `trdy_n` are both low and the bus is active, meaning `frame_n` or `irdy_n` is low. The busy counter (address 3) adds one per data clock.
- R3: A clock with `frame_n` and `irdy_n` both high is idle, and the idle counter (address 2) adds one for it. A clock with the bus active but no data moving (overhead) adds to neither the idle counter nor the busy counter.
- R4: Master m (1..5, wired to bit m-1 of `req_n`/`gnt_n`) starts a transaction on a clock where `frame_n` is low, the previous clock was idle, and `gnt_n[m-1]` was low on the previous clock. Its grant counter (address 3+m) adds exactly one per transaction, however many clocks the transaction lasts.
- R5: A transaction start seen while `local_init` is high belongs to the local device and adds to no master's grant counter.
- R6: The wait counter of master m (address 8+m) adds one on each clock where `req_n[m-1]` is low and master m neither starts a transaction on that clock nor owns the transaction in progress. This counts clocks where another master holds the bus. Ownership ends at the next idle clock.
- R7: Counters change only while the control mode field (bits 2:0 of address 0) equals 4. With any other mode they hold their values.
- R8: A counter at all-ones stays there. An event that arrives while it is there sets that counter's overflow flag, and the flag stays set. The flags read at address 1: bit 0 is idle, bit 1 is busy, bits 2..6 are grants for masters 1..5, and bits 7..11 are waits for masters 1..5.
- R9: A write to address 0 with bit 31 set zeroes all counters and flags at that clock edge, overriding any event on that clock. The same write loads the mode field.
- R10: A read with `rd_en` high loads `rdata` at the clock edge with the addressed value as it stood just before that edge. Address 0 returns the mode field, and any address above 13 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitored bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Bus transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| local_init | input | 1 | High when the local device is the initiator |
| req_n | input | NMST | Per-master bus request, active low |
| gnt_n | input | NMST | Per-master bus grant, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Register write data |
| rdata | output | DW | Registered read data |

## Verification
The assertion that at most one master starts a transaction on a clock depends on the arbiter driving no more than one grant low at a time. The random stimulus therefore picks either no grant or a single grant for each clock, while requests and the bus control lines vary freely. The register port is never written and read on the same clock. The saturation checks rely on the bench building the block with narrow counters, so that all-ones is reached within a short run.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  // Register map anchors (counter slots follow CNT_BASE in flag-bit order)
  localparam int A_CTRL   = 0;
  localparam int A_OVF    = 1;
  localparam int CNT_BASE = 2;
  localparam int CLR_BIT  = 31;

  // Bus activity: a transaction is open while framing or initiator-ready is low
  function automatic logic bus_open(input logic frame_n, input logic irdy_n);
    return !frame_n || !irdy_n;
  endfunction

  // A word moves when the bus is open and both sides are ready
  function automatic logic word_moves(input logic frame_n, input logic irdy_n,
                                      input logic trdy_n);
    return bus_open(frame_n, irdy_n) && !irdy_n && !trdy_n;
  endfunction
endpackage

// File: rtl/pmon_classify.sv
module pmon_classify import pmon_pkg::*; #(
  parameter int NMST = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic            local_init,
  input  logic [NMST-1:0] req_n,
  input  logic [NMST-1:0] gnt_n,
  output logic            ev_idle,
  output logic            ev_data,
  output logic            ev_ovh,
  output logic [NMST-1:0] ev_start,
  output logic [NMST-1:0] ev_wait
);
  logic            prev_idle_q;
  logic [NMST-1:0] prev_gnt_q;
  logic [NMST-1:0] owner_q;
  logic            fresh_frame;

  assign ev_data     = word_moves(frame_n, irdy_n, trdy_n);
  assign ev_idle     = !bus_open(frame_n, irdy_n);
  assign ev_ovh      = bus_open(frame_n, irdy_n) && !ev_data;
  assign fresh_frame = prev_idle_q && !frame_n && !local_init;

  for (genvar m = 0; m < NMST; m++) begin : g_mst
    assign ev_start[m] = fresh_frame && prev_gnt_q[m];
    assign ev_wait[m]  = !req_n[m] && !owner_q[m] && !ev_start[m];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           owner_q[m] <= 1'b0;
      else if (ev_start[m]) owner_q[m] <= 1'b1;
      else if (ev_idle)     owner_q[m] <= 1'b0;
    end

    // A master that has just begun owns the bus on the following clock
    assert_wait_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start[m] |=> !ev_wait[m]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_idle_q <= 1'b1;
      prev_gnt_q  <= '0;
    end else begin
      prev_idle_q <= ev_idle;
      prev_gnt_q  <= ~gnt_n;
    end
  end

  assert_start_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_start));
  assert_start_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_start) |=> !(|ev_start));
  assert_local_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    local_init |-> !(|ev_start));
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic at_top;
  assign at_top = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (inc) begin
      if (at_top) ovf <= 1'b1;
      else        cnt <= cnt + 1'b1;
    end
  end

  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !clr) |=> (cnt == TOP));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !ovf));
  assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/pci_evmon.sv
module pci_evmon import pmon_pkg::*; #(
  parameter int NMST    = 5,
  parameter int CNT_W   = 32,
  parameter int DW      = 32,
  parameter int AW      = 4,
  parameter int MODE_W  = 3,
  parameter int MODE_ON = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic            local_init,
  input  logic [NMST-1:0] req_n,
  input  logic [NMST-1:0] gnt_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  localparam int NCNT = 2 + 2 * NMST;

  logic              ev_idle, ev_data, ev_ovh;
  logic [NMST-1:0]   ev_start, ev_wait;
  logic [NCNT-1:0]   ev_vec, inc_vec, ovf_vec;
  logic [CNT_W-1:0]  cnt_q [NCNT];
  logic [MODE_W-1:0] mode_q;
  logic              mon_en, ctrl_wr, clr;
  logic [DW-1:0]     rd_val;

  pmon_classify #(.NMST(NMST)) u_class (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .local_init(local_init), .req_n(req_n), .gnt_n(gnt_n),
    .ev_idle(ev_idle), .ev_data(ev_data), .ev_ovh(ev_ovh),
    .ev_start(ev_start), .ev_wait(ev_wait)
  );

  assign ev_vec  = {ev_wait, ev_start, ev_data, ev_idle};
  assign mon_en  = (mode_q == MODE_W'(MODE_ON));
  assign inc_vec = ev_vec & {NCNT{mon_en}};
  assign ctrl_wr = wr_en && (addr == AW'(A_CTRL));
  assign clr     = ctrl_wr && wdata[CLR_BIT];

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    pmon_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc_vec[i]),
      .cnt(cnt_q[i]), .ovf(ovf_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (ctrl_wr) mode_q <= wdata[MODE_W-1:0];
  end

  always_comb begin
    rd_val = '0;
    if (addr == AW'(A_CTRL)) rd_val = DW'(mode_q);
    if (addr == AW'(A_OVF))  rd_val = DW'(ovf_vec);
    for (int i = 0; i < NCNT; i++)
      if (addr == AW'(CNT_BASE + i)) rd_val = DW'(cnt_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  // Overhead clocks feed neither the idle nor the busy counter
  assert_ovh_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ovh && !clr) |=> ($stable(cnt_q[0]) && $stable(cnt_q[1])));
  assert_disabled_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && !clr) |=> $stable(ovf_vec));
  assert_ctrl_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(A_CTRL)) |=> (rdata == DW'($past(mode_q))));
endmodule

// File: tb/pci_evmon_tb.sv
module pci_evmon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM   = 5;
  localparam int CW   = 9;
  localparam int NC   = 2 + 2 * NM;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1, irdy_n = 1, trdy_n = 1, local_init = 0;
  logic [NM-1:0] req_n = '1, gnt_n = '1;
  logic wr_en = 0, rd_en = 0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0, n_bad = 0;
  int m_cnt [NC];
  int m_ovf [NC];
  int m_mode;
  bit m_prev_idle;
  bit [NM-1:0] m_prev_gnt, m_owner;
  string cur_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_evmon #(.NMST(NM), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .local_init(local_init), .req_n(req_n), .gnt_n(gnt_n),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic int ref_read(input int a);
    int v = 0;
    if (a == 0) v = m_mode;
    else if (a == 1) begin
      for (int i = 0; i < NC; i++) if (m_ovf[i] != 0) v = v | (1 << i);
    end else if (a >= 2 && a < 2 + NC) v = m_cnt[a-2];
    return v;
  endfunction

  function automatic int ref_bump(input int v);
    return (v == MAXV) ? v : v + 1;
  endfunction

  task automatic check(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Advance one clock and apply the reference rules to the inputs held over it
  task automatic tick();
    bit open, moving, idle, clear;
    bit [NC-1:0] ev;
    @(posedge clk);
    @(negedge clk);
    if (rd_en) check(int'(rdata), ref_read(int'(addr)), cur_tag);
    open   = !frame_n || !irdy_n;
    moving = open && !irdy_n && !trdy_n;
    idle   = !open;
    ev[0] = idle;
    ev[1] = moving;
    for (int m = 0; m < NM; m++) begin
      bit st;
      st = m_prev_idle && !frame_n && !local_init && m_prev_gnt[m];
      ev[2+m]    = st;
      ev[2+NM+m] = !req_n[m] && !m_owner[m] && !st;
      if (st) m_owner[m] = 1'b1;
      else if (idle) m_owner[m] = 1'b0;
    end
    clear = wr_en && addr == 0 && wdata[31];
    for (int i = 0; i < NC; i++) begin
      if (clear) begin m_cnt[i] = 0; m_ovf[i] = 0; end
      else if (m_mode == 4 && ev[i]) begin
        if (m_cnt[i] == MAXV) m_ovf[i] = 1;
        m_cnt[i] = ref_bump(m_cnt[i]);
      end
    end
    if (wr_en && addr == 0) m_mode = int'(wdata[2:0]);
    m_prev_idle = idle;
    m_prev_gnt  = ~gnt_n;
  endtask

  task automatic read_chk(input int a, input string tag);
    cur_tag = tag; rd_en = 1; addr = 4'(a);
    tick();
    rd_en = 0;
  endtask

  task automatic write_ctrl(input int mode, input bit clear);
    wr_en = 1; addr = 0; wdata = {clear, 28'd0, 3'(mode)};
    tick();
    wr_en = 0;
  endtask

  task automatic bus(input bit f, input bit i, input bit t, input int cycles);
    frame_n = f; irdy_n = i; trdy_n = t;
    for (int k = 0; k < cycles; k++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_ovf[i] = 0; end
    m_mode = 0; m_prev_idle = 1; m_prev_gnt = '0; m_owner = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check(int'(rdata), 0, "R1 rdata");
    read_chk(0, "R1"); read_chk(3, "R1"); read_chk(1, "R1");
    // R7: disabled mode ignores idle clocks
    bus(1, 1, 1, 5);
    read_chk(2, "R7");
    check(int'(rdata), 0, "R7 idle disabled");
    // R3: idle counting once enabled
    write_ctrl(4, 1);
    bus(1, 1, 1, 6);
    read_chk(2, "R3");
    // R4/R2: master 2 multi-cycle transaction, master 4 waiting
    gnt_n = 5'b11101; bus(1, 1, 1, 1);
    req_n = 5'b10111;
    bus(0, 0, 1, 2);          // overhead clocks (R3)
    bus(0, 0, 0, 3);          // data clocks (R2)
    bus(1, 0, 0, 1);          // last data
    gnt_n = '1; bus(1, 1, 1, 1);
    req_n = '1;
    read_chk(5, "R4"); check(int'(rdata), 1, "R4 single grant");
    read_chk(3, "R2"); check(int'(rdata), 4, "R2 busy");
    read_chk(11, "R6");
    read_chk(2, "R3");
    // R5: local initiator with a stray grant
    gnt_n = 5'b11110; bus(1, 1, 1, 1);
    local_init = 1; bus(0, 0, 0, 2);
    local_init = 0; gnt_n = '1; bus(1, 1, 1, 2);
    read_chk(4, "R5"); check(int'(rdata), 0, "R5 no grant");
    // R9: clear overrides, then read zero
    write_ctrl(4, 1);
    read_chk(3, "R9"); check(int'(rdata), 0, "R9 cleared");
    // R8: saturation of the idle counter
    bus(1, 1, 1, MAXV + 20);
    read_chk(2, "R8"); check(int'(rdata), MAXV, "R8 saturate");
    read_chk(1, "R8");
    read_chk(15, "R10");
    // Random traffic
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 4000; k++) begin
      int g = $urandom_range(7);
      gnt_n = (g < NM) ? ~(NM'(1) << g) : '1;
      req_n = NM'($urandom);
      frame_n = ($urandom_range(3) == 0);
      irdy_n  = ($urandom_range(2) == 0);
      trdy_n  = ($urandom_range(2) == 0);
      if ($urandom_range(5) == 0) begin frame_n = 1; irdy_n = 1; end
      local_init = ($urandom_range(7) == 0);
      if ($urandom_range(400) == 0) begin
        wr_en = 1; addr = 0;
        wdata = {($urandom_range(1) == 1), 28'd0, (($urandom_range(3) == 0) ? 3'd1 : 3'd4)};
        cur_tag = "R9";
        tick(); wr_en = 0;
      end else if ($urandom_range(3) == 0) begin
        rd_en = 1; addr = 4'($urandom_range(15)); cur_tag = "R10";
        tick(); rd_en = 0;
      end else tick();
    end
    frame_n = 1; irdy_n = 1; trdy_n = 1; req_n = '1; gnt_n = '1; local_init = 0;
    for (int a = 0; a < 14; a++) read_chk(a, "R10");
    write_ctrl(4, 0);
    for (int a = 2; a < 14; a++) read_chk(a, "R6");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule